// File: doc/BRIEF.md
# Host Remote-DMA Data Port with Interrupt Status

This block lets a host processor reach a small local packet memory through a single data port. The host first loads a 16-bit remote address and a 16-bit remote byte count, each one byte at a time, through an 8-bit register interface. Each read or write on the data port then moves 1, 2 or 4 bytes. The address advances by that step and wraps from the ring's stop page back to its start page. The count shrinks by the step until it runs out, and then a completion flag is raised.

The same block holds the interrupt status and mask registers and drives a level interrupt line. Other engines can raise status bits 0 to 5 through event pulses. The block itself raises the remote-completion bit (bit 6) and the reset-indication bit (bit 7). The memory answers only in two windows: the low 32 bytes and a packet window set by parameters. Multi-byte data is stored least significant byte first.

Top module: `host_dma_port`

## Requirements
- R1: After reset the status register (offset 8) reads 0x80 and the mask (offset 9), address and count all read 0. The interrupt output is low, even when bit 7 alone is set in both status and mask.
- R2: The remote address is written and read as low byte at offset 3 and high byte at offset 4. The remote count uses offset 5 (low) and offset 6 (high).
- R3: One data-port access uses a step of 4 when `dp_quad` is high. Otherwise the step is 2 when bit 0 of the configuration register (offset 7) is set, and 1 when it is clear. The address advances by the step from its unaligned value.
- R4: On each access, if the count is at or below the step it becomes 0 and status bit 6 sets. Otherwise the count drops by the step.
- R5: If the advanced address equals the stop page (offset 2) shifted left by PAGE_SHIFT, the address is reloaded with the start page (offset 1) shifted by the same amount.
- R6: A data-port write while the count is zero changes neither memory, address nor count.
- R7: A command write (offset 0) that has bit 0 clear and bit 3 or bit 4 set, made while the count is zero, sets status bit 6 on the next cycle. With bit 0 set, or with a nonzero count, the command sets nothing.
- R8: A command write with bit 0 clear clears status bit 7. One with bit 0 set leaves bit 7 unchanged.
- R9: Writing offset 8 clears each status bit 0 to 6 that is written as 1, and bit 7 is immune. A pulse on `ev_flags[k]` sets status bit k. A set wins over a clear in the same cycle.
- R10: `irq` is high exactly when some bit 0 to 6 is set in both status and mask.
- R11: Bytes below address 32 and in [WIN_LO, WIN_HI) are valid. Outside them, writes are dropped and reads return 0xFF in every active lane. Wide accesses force the address even. Data is little-endian, and lanes above the step read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe (ignored when dp_rd is high) |
| dp_quad | input | 1 | 32-bit data-port access |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Data-port read data at the current address (combinational) |
| ev_flags | input | 6 | Event pulses that set status bits 0 to 5 |
| irq | output | 1 | Interrupt request |

## Verification
Register and data-port read data are combinational, so the bench samples them 1 ns after it sets the offset or raises the read strobe, before the clock edge. Every update of address, count, status and memory is due one clock edge after its stimulus. The bench drives each stimulus 1 ns after a rising edge, lets exactly one edge pass, and then reads back. The completion raised by a zero-length command is therefore checked on the first read after that single edge. So is the set-over-clear case, where an event pulse and a clear write arrive together.

// File: rtl/host_dma_port.sv
module host_dma_port #(
  parameter int AW         = 16,
  parameter int LOW_LIMIT  = 32,
  parameter int WIN_LO     = 64,
  parameter int WIN_HI     = 128,
  parameter int PAGE_SHIFT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic        dp_quad,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  input  logic [5:0]  ev_flags,
  output logic        irq
);
  localparam int MW = $clog2(WIN_HI);

  logic [7:0]    cmd_q, start_q, stop_q, cfg_q, isr_q, imr_q;
  logic [AW-1:0] addr_q, cnt_q;
  logic [7:0]    mem [WIN_HI];

  logic [2:0]    step;
  logic          wide, base_ok, do_wr, do_acc, cnt_done, cmd_wr, zero_len;
  logic [AW-1:0] base, addr_inc, addr_nxt, start_addr, stop_addr, step_w;
  logic [AW-1:0] lane_idx [4];
  logic [3:0]    lane_on, lane_in;
  logic [7:0]    isr_set, isr_clr;

  assign wide       = dp_quad | cfg_q[0];
  assign step       = dp_quad ? 3'd4 : (cfg_q[0] ? 3'd2 : 3'd1);
  assign step_w     = AW'(step);
  assign base       = wide ? {addr_q[AW-1:1], 1'b0} : addr_q;
  assign base_ok    = (int'(base) < LOW_LIMIT) || (int'(base) >= WIN_LO && int'(base) < WIN_HI);
  assign do_wr      = dp_wr & ~dp_rd & (cnt_q != '0);
  assign do_acc     = dp_rd | do_wr;
  assign cnt_done   = cnt_q <= step_w;
  assign start_addr = AW'(start_q) << PAGE_SHIFT;
  assign stop_addr  = AW'(stop_q) << PAGE_SHIFT;
  assign addr_inc   = addr_q + step_w;
  assign addr_nxt   = (addr_inc == stop_addr) ? start_addr : addr_inc;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_idx[k] = base + AW'(k);
    assign lane_on[k]  = k < int'(step);
    assign lane_in[k]  = base_ok && (int'(lane_idx[k]) < WIN_HI);
    assign dp_rdata[8*k +: 8] = !lane_on[k] ? 8'h00 :
                                lane_in[k] ? mem[lane_idx[k][MW-1:0]] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (do_wr && lane_on[k] && lane_in[k])
        mem[lane_idx[k][MW-1:0]] <= dp_wdata[8*k +: 8];
  end

  assign cmd_wr   = reg_we && reg_addr == 4'd0;
  assign zero_len = cmd_wr && !reg_wdata[0] && (reg_wdata[3] || reg_wdata[4]) && cnt_q == '0;
  assign isr_set  = {1'b0, (do_acc && cnt_done) || zero_len, ev_flags};
  assign isr_clr  = {cmd_wr && !reg_wdata[0],
                     (reg_we && reg_addr == 4'd8) ? reg_wdata[6:0] : 7'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 8'h01; start_q <= '0; stop_q <= '0; cfg_q <= '0;
      isr_q <= 8'h80; imr_q <= '0; addr_q <= '0; cnt_q <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (reg_we) begin
        case (reg_addr)
          4'd0: cmd_q   <= reg_wdata;
          4'd1: start_q <= reg_wdata;
          4'd2: stop_q  <= reg_wdata;
          4'd3: addr_q[7:0]    <= reg_wdata;
          4'd4: addr_q[AW-1:8] <= reg_wdata[AW-9:0];
          4'd5: cnt_q[7:0]     <= reg_wdata;
          4'd6: cnt_q[AW-1:8]  <= reg_wdata[AW-9:0];
          4'd7: cfg_q   <= reg_wdata;
          4'd9: imr_q   <= reg_wdata;
          default: ;
        endcase
      end else if (do_acc) begin
        addr_q <= addr_nxt;
        cnt_q  <= cnt_done ? '0 : cnt_q - step_w;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0: reg_rdata = cmd_q;
      4'd1: reg_rdata = start_q;
      4'd2: reg_rdata = stop_q;
      4'd3: reg_rdata = addr_q[7:0];
      4'd4: reg_rdata = 8'(addr_q[AW-1:8]);
      4'd5: reg_rdata = cnt_q[7:0];
      4'd6: reg_rdata = 8'(cnt_q[AW-1:8]);
      4'd7: reg_rdata = cfg_q;
      4'd8: reg_rdata = isr_q;
      4'd9: reg_rdata = imr_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = |(isr_q[6:0] & imr_q[6:0]);

  a_r4_count_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !reg_we && cnt_q != '0) |=> cnt_q < $past(cnt_q));
  a_r4_done_on_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !reg_we && cnt_q <= step_w) |=> (isr_q[6] && cnt_q == '0));
  a_r6_zero_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && !dp_rd && !reg_we && cnt_q == '0) |=> ($stable(addr_q) && $stable(cnt_q)));
  a_r7_zero_length_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    zero_len |=> isr_q[6]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flags[0] |=> isr_q[0]);
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q[6:0] == 7'd0) |-> !irq);
endmodule

// File: tb/host_dma_port_tb.sv
module host_dma_port_tb_top;
  logic        clk = 0, rst_n = 0, reg_we = 0, dp_rd = 0, dp_wr = 0, dp_quad = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [31:0] dp_wdata = 0, dp_rdata;
  logic [5:0]  ev_flags = 0;
  logic        irq;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  host_dma_port dut_i (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .dp_rd, .dp_wr, .dp_quad, .dp_wdata, .dp_rdata, .ev_flags, .irq);

  // {wide[39:36], quad[35:32], count[31:16], exp_addr_lo[15:8], exp_count[7:0]}; start address 0x40
  localparam logic [39:0] VEC [6] = '{
    {4'h0, 4'h0, 16'd5, 8'h41, 8'd4},
    {4'h1, 4'h0, 16'd5, 8'h42, 8'd3},
    {4'h0, 4'h1, 16'd5, 8'h44, 8'd1},
    {4'h1, 4'h0, 16'd2, 8'h42, 8'd0},
    {4'h0, 4'h1, 16'd3, 8'h44, 8'd0},
    {4'h0, 4'h0, 16'd1, 8'h41, 8'd0}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic dp(bit rd, bit quad, logic [31:0] wd, output logic [31:0] rd_data);
    dp_rd = rd; dp_wr = !rd; dp_quad = quad; dp_wdata = wd;
    #1 rd_data = dp_rdata;
    @(posedge clk); #1 dp_rd = 0; dp_wr = 0; dp_quad = 0;
  endtask

  task automatic setup(logic [7:0] cfg, logic [15:0] a, logic [15:0] c);
    wreg(7, cfg); wreg(3, a[7:0]); wreg(4, a[15:8]); wreg(5, c[7:0]); wreg(6, c[15:8]);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] r;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rreg(8, r); check("R1 status", r, 8'h80);
    rreg(9, r); check("R1 mask", r, 8'h00);
    rreg(3, r); check("R1 addr", r, 8'h00);
    rreg(5, r); check("R1 count", r, 8'h00);
    check("R1 irq", irq, 0);
    wreg(9, 8'h80); #1 check("R1 irq bit7 excluded", irq, 0);
    wreg(9, 8'h00);

    wreg(0, 8'h01); rreg(8, r); check("R8 stop set keeps bit7", r, 8'h80);
    wreg(8, 8'h80); rreg(8, r); check("R9 bit7 immune to clear", r, 8'h80);
    wreg(0, 8'h00); rreg(8, r); check("R8 stop clear clears bit7", r, 8'h00);

    wreg(3, 8'h34); wreg(4, 8'h12); wreg(5, 8'h78); wreg(6, 8'h56);
    rreg(3, r); check("R2 addr lo", r, 8'h34);
    rreg(4, r); check("R2 addr hi", r, 8'h12);
    rreg(5, r); check("R2 count lo", r, 8'h78);
    rreg(6, r); check("R2 count hi", r, 8'h56);

    wreg(1, 8'h00); wreg(2, 8'hFF);
    foreach (VEC[i]) begin
      wreg(8, 8'h7F);
      setup({7'd0, VEC[i][36]}, 16'h0040, VEC[i][31:16]);
      dp(1, VEC[i][32], 0, d);
      rreg(3, r); check("R3 step address", r, VEC[i][15:8]);
      rreg(5, r); check("R4 count", r, VEC[i][7:0]);
      rreg(8, r); check("R4 done flag", r[6], VEC[i][7:0] == 0);
    end

    setup(8'h01, 16'h0045, 16'd4);
    dp(0, 0, 32'h0000BEEF, d);
    rreg(3, r); check("R3 advance from odd address", r, 8'h47);
    setup(8'h00, 16'h0044, 16'd2);
    dp(1, 0, 0, d); check("R11 little-endian low byte at even", d, 32'h000000EF);
    dp(1, 0, 0, d); check("R11 little-endian high byte", d, 32'h000000BE);

    setup(8'h00, 16'h0010, 16'd4);
    dp(0, 1, 32'h44332211, d);
    setup(8'h00, 16'h0010, 16'd4);
    dp(1, 1, 0, d); check("R11 quad readback", d, 32'h44332211);
    setup(8'h00, 16'h0012, 16'd1);
    dp(1, 0, 0, d); check("R11 byte inside quad", d, 32'h00000033);

    setup(8'h00, 16'h0030, 16'd1);
    dp(1, 0, 0, d); check("R11 out of range byte", d, 32'h000000FF);
    setup(8'h01, 16'h0031, 16'd2);
    dp(1, 0, 0, d); check("R11 out of range word", d, 32'h0000FFFF);

    setup(8'h00, 16'h0044, 16'd0);
    dp(0, 0, 32'h55, d);
    rreg(3, r); check("R6 address unchanged", r, 8'h44);
    rreg(5, r); check("R6 count unchanged", r, 8'h00);
    wreg(5, 8'd1);
    dp(1, 0, 0, d); check("R6 memory unchanged", d, 32'h000000EF);

    wreg(1, 8'h04); wreg(2, 8'h05);
    setup(8'h00, 16'h004F, 16'd3);
    dp(1, 0, 0, d);
    rreg(3, r); check("R5 wrap byte", r, 8'h40);
    rreg(4, r); check("R5 wrap hi", r, 8'h00);
    setup(8'h01, 16'h004E, 16'd4);
    dp(1, 0, 0, d);
    rreg(3, r); check("R5 wrap word", r, 8'h40);
    wreg(1, 8'h00); wreg(2, 8'hFF);

    wreg(8, 8'h7F); wreg(5, 8'h00); wreg(6, 8'h00);
    wreg(0, 8'h08); rreg(8, r); check("R7 zero-length sets done", r, 8'h40);
    wreg(8, 8'h7F); wreg(0, 8'h19); rreg(8, r); check("R7 stopped command ignored", r, 8'h00);
    wreg(5, 8'd3); wreg(0, 8'h10); rreg(8, r); check("R7 nonzero count no done", r, 8'h00);

    ev_flags = 6'h3F; @(posedge clk); #1 ev_flags = 0;
    rreg(8, r); check("R9 event set", r, 8'h3F);
    wreg(8, 8'h05); rreg(8, r); check("R9 write one clears", r, 8'h3A);
    ev_flags = 6'h02; reg_we = 1; reg_addr = 8; reg_wdata = 8'h02;
    @(posedge clk); #1 ev_flags = 0; reg_we = 0;
    rreg(8, r); check("R9 set wins over clear", r, 8'h3A);

    wreg(9, 8'h01); #1 check("R10 irq masked bit clear", irq, 0);
    wreg(9, 8'h02); #1 check("R10 irq asserted", irq, 1);
    wreg(8, 8'h02); #1 check("R10 irq drops after clear", irq, 0);

    finished = 1;
    report();
  end
endmodule